// File: doc/BRIEF.md
# Segmented Two/Four-Level Transmit Equalizer Allocator

This block sits between the parallel symbol stream of a serial transmitter and a segmented output driver. Each clock accepts one 2-bit symbol and shifts it into a five-stage tap line. The taps, from newest to oldest, are one pre-cursor, the main cursor and three post-cursors, one symbol apart. For every tap the block reports the symbol's sign and magnitude bits, and the enables for the driver segments that realise that tap's weight.

Every tap weight is a 7-bit value. Its low nibble switches segments owned by that tap alone. The three high bits request slices from a pool of seven segments that all taps share. The pool is handed out in a fixed order, with the pre-cursor first and the last post-cursor last. Each granted pool segment copies the sign and magnitude of the tap it serves. The driver can run with two levels or four. With two levels, only the outer levels are sent.

Weights and mode are held in configuration registers. These registers change only on a clock edge where the load strobe is high. The new values take effect from that edge onward.

Top module: `tx_ffe_seg_alloc`

## Requirements
- R1: A symbol code maps to levels as follows: 00 is outer positive, 01 is inner positive, 11 is inner negative and 10 is outer negative. For each tap, `tap_pol[t]` carries the code's high bit (1 = negative) and `tap_inner[t]` carries its low bit (1 = inner level).
- R2: While the active mode is two-level (`cfg_pam4` loaded as 0), every symbol enters the tap line with its low bit forced to 0. The high bit is kept.
- R3: The tap line orders symbols by age. Tap 0 (pre-cursor) holds the symbol taken at the latest clock edge. Tap 1 (main) holds the one before it, and taps 2 to 4 (post-cursors) hold progressively older symbols.
- R4: `ded_en[4t+3:4t]` equals bits [3:0] of tap t's active weight.
- R5: Shared segments are granted in index order from 0. Tap 0 is served first, then taps 1, 2, 3 and 4. Each tap receives as many segments as the value of bits [6:4] of its weight, so the enabled pool segments always form a contiguous run starting at index 0.
- R6: Each enabled shared segment drives the `tap_pol` and `tap_inner` values of the tap it is granted to.
- R7: A shared segment that no tap is granted has its enable, polarity and inner bits all at 0.
- R8: When the high fields of all five weights sum to more than 7, `cfg_err` is 1 and all seven pool segments are in use. Requests beyond the seventh segment are dropped, starting from the lowest-priority taps. Otherwise `cfg_err` is 0.
- R9: Weights (tap t at `cfg_weights[7t+6:7t]`) and mode are captured only on a clock edge with `cfg_load` high. They are ignored otherwise, and apply to outputs from that edge onward. The mode used on an edge's incoming symbol is the one that was active before that edge.
- R10: Reset clears the tap line to code 00, clears all weights and selects two-level mode. This leaves every segment enable, `cfg_err` and all tap bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_in | input | 2 | Incoming symbol code {high, low} |
| cfg_load | input | 1 | Configuration capture strobe |
| cfg_pam4 | input | 1 | Mode to load: 1 = four-level, 0 = two-level |
| cfg_weights | input | 35 | Five 7-bit tap weights, tap t at [7t+6:7t] |
| tap_pol | output | 5 | Per-tap sign bit |
| tap_inner | output | 5 | Per-tap inner-level bit |
| ded_en | output | 20 | Dedicated segment enables, 4 per tap |
| shr_en | output | 7 | Shared segment enables |
| shr_pol | output | 7 | Shared segment sign bits |
| shr_inner | output | 7 | Shared segment inner-level bits |
| cfg_err | output | 1 | Shared pool oversubscribed |

## Verification
Several properties are checked on every cycle. Each tap must equal the previous cycle's value of the tap before it. The pool enables must stay contiguous from index 0. An oversubscribed pool must be fully used. Otherwise, the number of enabled pool segments must equal the requested total, and two-level mode must never let an inner level into the line. Other behaviours can only be shown by the bench's scenarios. These are the exact assignment of pool segments to taps and the polarities they copy, the dropping order under overflow, the nibble passthrough, the Gray level mapping, and the rule that configuration changes without the strobe are ignored.

// File: rtl/tx_ffe_seg_alloc.sv
module tx_ffe_seg_alloc #(
  parameter int NTAP = 5,
  parameter int WB   = 7,
  parameter int DB   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           sym_in,
  input  logic                 cfg_load,
  input  logic                 cfg_pam4,
  input  logic [NTAP*WB-1:0]   cfg_weights,
  output logic [NTAP-1:0]      tap_pol,
  output logic [NTAP-1:0]      tap_inner,
  output logic [NTAP*DB-1:0]   ded_en,
  output logic [(1<<(WB-DB))-2:0] shr_en,
  output logic [(1<<(WB-DB))-2:0] shr_pol,
  output logic [(1<<(WB-DB))-2:0] shr_inner,
  output logic                 cfg_err
);
  localparam int UB   = WB - DB;
  localparam int NSHR = (1 << UB) - 1;

  logic [1:0]         dl [NTAP];
  logic [NTAP*WB-1:0] w_q;
  logic               pam4_q;
  int                 total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAP; i++) dl[i] <= 2'b00;
      w_q    <= '0;
      pam4_q <= 1'b0;
    end else begin
      dl[0] <= {sym_in[1], sym_in[0] & pam4_q};
      for (int i = 1; i < NTAP; i++) dl[i] <= dl[i-1];
      if (cfg_load) begin
        w_q    <= cfg_weights;
        pam4_q <= cfg_pam4;
      end
    end
  end

  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    assign tap_pol[t]            = dl[t][1];
    assign tap_inner[t]          = dl[t][0];
    assign ded_en[t*DB +: DB]    = w_q[t*WB +: DB];
  end

  always_comb begin
    int acc;
    int u;
    acc       = 0;
    shr_en    = '0;
    shr_pol   = '0;
    shr_inner = '0;
    for (int t = 0; t < NTAP; t++) begin
      u = int'(w_q[t*WB+DB +: UB]);
      for (int s = 0; s < NSHR; s++) begin
        if (s >= acc && s < acc + u) begin
          shr_en[s]    = 1'b1;
          shr_pol[s]   = dl[t][1];
          shr_inner[s] = dl[t][0];
        end
      end
      acc = acc + u;
    end
    total = acc;
  end

  assign cfg_err = (total > NSHR);
endmodule

// File: rtl/tx_ffe_seg_alloc_chk.sv
module tx_ffe_seg_alloc_chk #(
  parameter int NTAP = 5,
  parameter int WB   = 7,
  parameter int DB   = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NTAP-1:0]           tap_pol,
  input logic [NTAP-1:0]           tap_inner,
  input logic [(1<<(WB-DB))-2:0]   shr_en,
  input logic                      cfg_err,
  input logic                      pam4_q,
  input logic [NTAP*WB-1:0]        w_q
);
  localparam int UB   = WB - DB;
  localparam int NSHR = (1 << UB) - 1;

  function automatic int req_sum(input logic [NTAP*WB-1:0] w);
    int s;
    s = 0;
    for (int t = 0; t < NTAP; t++) s = s + int'(w[t*WB+DB +: UB]);
    return s;
  endfunction

  for (genvar t = 1; t < NTAP; t++) begin : g_shift
    a_r3_tap_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_pol[t] == $past(tap_pol[t-1])) && (tap_inner[t] == $past(tap_inner[t-1])));
  end

  a_r2_two_level_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pam4_q) |-> !tap_inner[0]);

  a_r5_pool_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (shr_en & (shr_en + 1'b1)) == '0);

  a_r8_overflow_full: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (&shr_en));

  a_r8_grant_count: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_err |-> ($countones(shr_en) == req_sum(w_q)));
endmodule

bind tx_ffe_seg_alloc tx_ffe_seg_alloc_chk #(.NTAP(NTAP), .WB(WB), .DB(DB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tap_pol   (tap_pol),
  .tap_inner (tap_inner),
  .shr_en    (shr_en),
  .cfg_err   (cfg_err),
  .pam4_q    (pam4_q),
  .w_q       (w_q)
);

// File: tb/tx_ffe_seg_alloc_bench.sv
module tx_ffe_seg_alloc_bench;
  localparam int PERIOD = 10;
  localparam int NTAP = 5, WB = 7, DB = 4, NSHR = 7;

  typedef struct packed {
    logic [NTAP-1:0]    pol;
    logic [NTAP-1:0]    inner;
    logic [NTAP*DB-1:0] ded;
    logic [NSHR-1:0]    sen;
    logic [NSHR-1:0]    spol;
    logic [NSHR-1:0]    sinn;
    logic               err;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sym_in = 2'b00;
  logic cfg_load = 1'b0;
  logic cfg_pam4 = 1'b0;
  logic [NTAP*WB-1:0] cfg_weights = '0;
  logic [NTAP-1:0] tap_pol, tap_inner;
  logic [NTAP*DB-1:0] ded_en;
  logic [NSHR-1:0] shr_en, shr_pol, shr_inner;
  logic cfg_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t q[$];

  logic [1:0]         m_dl [NTAP];
  logic [NTAP*WB-1:0] m_w;
  logic               m_pam4;

  always #(PERIOD/2) clk = ~clk;

  tx_ffe_seg_alloc u_tx_ffe_seg_alloc (
    .clk(clk), .rst_n(rst_n), .sym_in(sym_in), .cfg_load(cfg_load),
    .cfg_pam4(cfg_pam4), .cfg_weights(cfg_weights), .tap_pol(tap_pol),
    .tap_inner(tap_inner), .ded_en(ded_en), .shr_en(shr_en),
    .shr_pol(shr_pol), .shr_inner(shr_inner), .cfg_err(cfg_err)
  );

  function automatic logic [NTAP*WB-1:0] pack_w(input logic [6:0] a, b, c, d, e);
    return {e, d, c, b, a};
  endfunction

  function automatic exp_t model_out();
    exp_t e;
    int next;
    int u;
    e = '0;
    next = 0;
    for (int t = 0; t < NTAP; t++) begin
      e.pol[t]   = m_dl[t][1];
      e.inner[t] = m_dl[t][0];
      e.ded[t*DB +: DB] = m_w[t*WB +: DB];
      u = int'(m_w[t*WB+DB +: 3]);
      for (int k = 0; k < u; k++) begin
        if (next < NSHR) begin
          e.sen[next]  = 1'b1;
          e.spol[next] = m_dl[t][1];
          e.sinn[next] = m_dl[t][0];
          next++;
        end else begin
          e.err = 1'b1;
        end
      end
    end
    return e;
  endfunction

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] s, input logic ld, input logic pm,
                      input logic [NTAP*WB-1:0] w, input logic rst_v);
    @(negedge clk);
    sym_in = s; cfg_load = ld; cfg_pam4 = pm; cfg_weights = w; rst_n = !rst_v;
    if (rst_v) begin
      for (int i = 0; i < NTAP; i++) m_dl[i] = 2'b00;
      m_w = '0; m_pam4 = 1'b0;
    end else begin
      for (int i = NTAP-1; i > 0; i--) m_dl[i] = m_dl[i-1];
      m_dl[0] = {s[1], s[0] & m_pam4};
      if (ld) begin m_w = w; m_pam4 = pm; end
    end
    q.push_back(model_out());
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    #(PERIOD/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp("R1/R3", "tap_pol",   32'(tap_pol),   32'(e.pol));
      cmp("R1/R2", "tap_inner", 32'(tap_inner), 32'(e.inner));
      cmp("R4",    "ded_en",    32'(ded_en),    32'(e.ded));
      cmp("R5/R7", "shr_en",    32'(shr_en),    32'(e.sen));
      cmp("R6",    "shr_pol",   32'(shr_pol),   32'(e.spol));
      cmp("R6",    "shr_inner", 32'(shr_inner), 32'(e.sinn));
      cmp("R8",    "cfg_err",   32'(cfg_err),   32'(e.err));
    end
  end

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [NTAP*WB-1:0] wa, wb, wo;
    for (int i = 0; i < NTAP; i++) m_dl[i] = 2'b00;
    m_w = '0; m_pam4 = 1'b0;
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    // R10: reset state at the ports
    cmp("R10", "ded_en", 32'(ded_en), 0);
    cmp("R10", "shr_en", 32'(shr_en), 0);
    cmp("R10", "cfg_err", 32'(cfg_err), 0);
    cmp("R10", "taps", 32'({tap_pol, tap_inner}), 0);

    // R1 R3 R5 R6: four-level traffic, pool exactly filled (1+3+2+0+1)
    wa = pack_w(7'h12, 7'h3F, 7'h25, 7'h08, 7'h11);
    step(2'b01, 1'b1, 1'b1, wa, 1'b0);
    for (int i = 0; i < 24; i++) step(2'($urandom_range(3)), 1'b0, 1'b0, '0, 1'b0);
    step(2'b00, 1'b0, 1'b0, '0, 1'b0);
    step(2'b01, 1'b0, 1'b0, '0, 1'b0);
    step(2'b11, 1'b0, 1'b0, '0, 1'b0);
    step(2'b10, 1'b0, 1'b0, '0, 1'b0);

    // R9: changing config without the strobe has no effect
    wb = pack_w(7'h7F, 7'h7F, 7'h7F, 7'h7F, 7'h7F);
    for (int i = 0; i < 6; i++) step(2'($urandom_range(3)), 1'b0, 1'b0, wb, 1'b0);

    // R2: two-level mode; new mode applies to symbols after the load edge
    step(2'b11, 1'b1, 1'b0, wa, 1'b0);
    for (int i = 0; i < 10; i++) step(2'b01 | 2'($urandom_range(1) << 1), 1'b0, 1'b0, '0, 1'b0);

    // R8: oversubscribed pool 3+3+3+0+2, post1 gets one segment, post3 none
    wo = pack_w(7'h35, 7'h3A, 7'h31, 7'h04, 7'h2C);
    step(2'b00, 1'b1, 1'b1, wo, 1'b0);
    for (int i = 0; i < 10; i++) step(2'($urandom_range(3)), 1'b0, 1'b0, '0, 1'b0);

    // R5 boundary: pre takes all seven; R7: no requests leave the pool idle
    step(2'b10, 1'b1, 1'b1, pack_w(7'h7F, 7'h0F, 7'h00, 7'h00, 7'h00), 1'b0);
    for (int i = 0; i < 4; i++) step(2'($urandom_range(3)), 1'b0, 1'b0, '0, 1'b0);
    step(2'b11, 1'b1, 1'b1, pack_w(7'h0F, 7'h05, 7'h0A, 7'h03, 7'h01), 1'b0);
    for (int i = 0; i < 4; i++) step(2'($urandom_range(3)), 1'b0, 1'b0, '0, 1'b0);

    // R10: reset in mid-run, then recovery
    step(2'b11, 1'b0, 1'b0, '0, 1'b1);
    step(2'b01, 1'b0, 1'b0, '0, 1'b1);
    step(2'b11, 1'b1, 1'b1, wa, 1'b0);
    for (int i = 0; i < 6; i++) step(2'($urandom_range(3)), 1'b0, 1'b0, '0, 1'b0);

    @(posedge clk);
    #(PERIOD/2);
    done = 1'b1;
    finish_run();
  end
endmodule